// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutation Controller

This block commutates a three-phase brushless DC motor in hardware. Three Hall-sensor lines are synchronised and debounced. The resulting 3-bit code selects one of six rotor sectors. In each sector, one phase switches as a complementary PWM pair, one phase is held on its low side, and one phase is left floating. A shared duty value sets the PWM on-time. A direction bit swaps the high-side and low-side roles. The processor only supplies enable, direction and duty, and does no work on any sector change.

The gates are protected in three ways. Any change of a phase's gate request is separated by a programmable dead time. Hall codes 000 and 111 force every gate off and latch a fault flag. Dropping the enable input clears every gate at the next clock edge. Accepted Hall transitions are counted in a wrapping counter.

Top module: `hall_commutator`

## Requirements
- R1: Each Hall line passes through two synchronising flops. A change is accepted only after the synchronised level has differed from the accepted level for FILTER_LEN consecutive clocks. A pulse of FILTER_LEN-1 clocks changes neither the gates nor the transition count.
- R2: The Hall code is c = {hall[2],hall[1],hall[0]}. Gate index 0, 1 and 2 are phases A, B and C. With dir=0 the mapping from code to (high-side phase, low-side phase) is: 5 gives (A,B), 4 gives (A,C), 6 gives (B,C), 2 gives (B,A), 3 gives (C,A), 1 gives (C,B). The third phase floats.
- R3: With dir=1, each sector swaps the two roles of R2: the high-side phase becomes the low-side phase and the reverse.
- R4: The high-side phase drives gate_hi while the carrier count is below the latched duty, and drives gate_lo otherwise. The low-side phase holds gate_lo on. A floating phase has both gates off. The carrier counts 0 to PWM_PERIOD-1 and wraps.
- R5: No phase ever has gate_hi and gate_lo on together, and at most one gate_hi is on at a time.
- R6: When the gate request of a phase changes, both of its gates are off for DEAD_CYCLES+1 clocks before the new request appears.
- R7: A new duty value is latched only when the carrier wraps to 0. A change in the middle of a period does not alter the current period.
- R8: Once all filters have settled, an accepted Hall code of 000 or 111 sets `fault`. The fault stays set until reset, and every gate stays off while it is set.
- R9: `edge_count` increases by exactly one for each clock in which at least one accepted Hall level changes. It wraps modulo 2^TCNT_W.
- R10: With enable low, all gates are off after the next clock edge. Re-enabling applies the dead time of R6.
- R11: After reset, all gates are off, `fault` is 0 and `edge_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Gate drive enable |
| dir | input | 1 | Rotation direction, 1 swaps high/low roles |
| duty | input | PWM_W | PWM on-time in carrier counts |
| hall | input | 3 | Raw Hall-sensor lines |
| gate_hi | output | 3 | High-side gates, index 0 = phase A |
| gate_lo | output | 3 | Low-side gates, index 0 = phase A |
| fault | output | 1 | Sticky invalid-Hall-code flag |
| edge_count | output | TCNT_W | Accepted Hall transition counter |

## Verification
The bench drives Hall glitches exactly one clock shorter than the filter length. A filter off by one would count a phantom edge or start a sector change. It changes duty in the middle of a period. A design that latches early would lose the low-side gate before the carrier wraps. Every rising gate is checked against how long the opposite gate of its phase has been off. A dead time that is missing or one clock short would show up there, as would any path from enable, fault or direction that skips the dead time. Three hundred sector steps show counter wrap. An invalid code, followed by a valid one, shows whether the fault and the gate blanking are sticky.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [1:0] {
    PH_FLOAT = 2'b00,
    PH_HIGH  = 2'b01,
    PH_LOW   = 2'b10
  } phase_role_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

  localparam int NUM_PHASES = 3;
endpackage

// File: rtl/hc_input_filter.sv
module hc_input_filter #(
  parameter int FILTER_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic primed,
  output logic flip
);
  localparam int CW = (FILTER_LEN > 1) ? $clog2(FILTER_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILTER_LEN - 1);

  logic          sync_a;
  logic          sync_b;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a  <= 1'b0;
      sync_b  <= 1'b0;
      level   <= 1'b0;
      primed  <= 1'b0;
      flip    <= 1'b0;
      run_cnt <= '0;
    end else begin
      sync_a <= pin;
      sync_b <= sync_a;
      flip   <= 1'b0;
      if (primed && (sync_b == level)) begin
        run_cnt <= '0;
      end else if (run_cnt == LAST) begin
        level   <= sync_b;
        primed  <= 1'b1;
        flip    <= primed;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hc_sector_map.sv
module hc_sector_map
  import hc_pkg::*;
(
  input  logic        [2:0] code,
  input  logic              dir,
  output phase_role_e       role [NUM_PHASES],
  output logic              valid
);
  logic [1:0] src_idx;
  logic [1:0] sink_idx;

  always_comb begin
    valid    = 1'b1;
    src_idx  = 2'd0;
    sink_idx = 2'd0;
    case (code)
      3'b101: begin src_idx = 2'd0; sink_idx = 2'd1; end
      3'b100: begin src_idx = 2'd0; sink_idx = 2'd2; end
      3'b110: begin src_idx = 2'd1; sink_idx = 2'd2; end
      3'b010: begin src_idx = 2'd1; sink_idx = 2'd0; end
      3'b011: begin src_idx = 2'd2; sink_idx = 2'd0; end
      3'b001: begin src_idx = 2'd2; sink_idx = 2'd1; end
      default: valid = 1'b0;
    endcase
    for (int p = 0; p < NUM_PHASES; p++) begin
      role[p] = PH_FLOAT;
      if (valid && (src_idx == 2'(p)))  role[p] = dir ? PH_LOW : PH_HIGH;
      if (valid && (sink_idx == 2'(p))) role[p] = dir ? PH_HIGH : PH_LOW;
    end
  end
endmodule

// File: rtl/hc_pwm_carrier.sv
module hc_pwm_carrier #(
  parameter int PWM_W      = 10,
  parameter int PWM_PERIOD = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PWM_W-1:0] duty,
  output logic             pwm_on
);
  localparam logic [PWM_W-1:0] TOP = PWM_W'(PWM_PERIOD - 1);

  logic [PWM_W-1:0] ramp;
  logic [PWM_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ramp   <= '0;
      duty_q <= '0;
    end else if (ramp == TOP) begin
      ramp   <= '0;
      duty_q <= duty;
    end else begin
      ramp <= ramp + 1'b1;
    end
  end

  assign pwm_on = (ramp < duty_q);
endmodule

// File: rtl/hc_phase_gate.sv
module hc_phase_gate
  import hc_pkg::*;
#(
  parameter int DEAD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  gate_pair_t req,
  output logic       gate_hi,
  output logic       gate_lo
);
  localparam int DW = (DEAD_CYCLES > 0) ? $clog2(DEAD_CYCLES + 1) : 1;
  localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_CYCLES);

  gate_pair_t    held;
  logic [DW-1:0] dead_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= '0;
      dead_cnt <= '0;
      gate_hi  <= 1'b0;
      gate_lo  <= 1'b0;
    end else if (!enable) begin
      held     <= '0;
      dead_cnt <= DEAD_LD;
      gate_hi  <= 1'b0;
      gate_lo  <= 1'b0;
    end else if (req != held) begin
      held     <= req;
      dead_cnt <= DEAD_LD;
      gate_hi  <= 1'b0;
      gate_lo  <= 1'b0;
    end else if (dead_cnt != '0) begin
      dead_cnt <= dead_cnt - 1'b1;
      gate_hi  <= 1'b0;
      gate_lo  <= 1'b0;
    end else begin
      gate_hi <= held.hi;
      gate_lo <= held.lo & ~held.hi;
    end
  end
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hc_pkg::*;
#(
  parameter int PWM_W       = 10,
  parameter int PWM_PERIOD  = 1000,
  parameter int FILTER_LEN  = 8,
  parameter int DEAD_CYCLES = 16,
  parameter int TCNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              dir,
  input  logic [PWM_W-1:0]  duty,
  input  logic [2:0]        hall,
  output logic [2:0]        gate_hi,
  output logic [2:0]        gate_lo,
  output logic              fault,
  output logic [TCNT_W-1:0] edge_count
);
  logic [2:0]  code;
  logic [2:0]  primed;
  logic [2:0]  flip;
  logic        all_primed;
  logic        code_ok;
  logic        run_ok;
  logic        pwm_on;
  phase_role_e role [NUM_PHASES];
  gate_pair_t  req  [NUM_PHASES];

  for (genvar i = 0; i < 3; i++) begin : g_line
    hc_input_filter #(.FILTER_LEN(FILTER_LEN)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .pin    (hall[i]),
      .level  (code[i]),
      .primed (primed[i]),
      .flip   (flip[i])
    );
  end

  assign all_primed = &primed;

  hc_sector_map u_map (
    .code  (code),
    .dir   (dir),
    .role  (role),
    .valid (code_ok)
  );

  hc_pwm_carrier #(.PWM_W(PWM_W), .PWM_PERIOD(PWM_PERIOD)) u_pwm (
    .clk    (clk),
    .rst    (rst),
    .duty   (duty),
    .pwm_on (pwm_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault      <= 1'b0;
      edge_count <= '0;
    end else begin
      if (all_primed && !code_ok) fault <= 1'b1;
      if (|flip) edge_count <= edge_count + 1'b1;
    end
  end

  assign run_ok = all_primed & code_ok & ~fault;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    always_comb begin
      req[p] = '0;
      if (run_ok) begin
        case (role[p])
          PH_HIGH: req[p] = '{hi: pwm_on, lo: ~pwm_on};
          PH_LOW:  req[p] = '{hi: 1'b0,   lo: 1'b1};
          default: req[p] = '0;
        endcase
      end
    end

    hc_phase_gate #(.DEAD_CYCLES(DEAD_CYCLES)) u_gate (
      .clk     (clk),
      .rst     (rst),
      .enable  (enable),
      .req     (req[p]),
      .gate_hi (gate_hi[p]),
      .gate_lo (gate_lo[p])
    );
  end
endmodule

// File: rtl/hc_checker.sv
module hc_checker #(
  parameter int TCNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [2:0]        gate_hi,
  input logic [2:0]        gate_lo,
  input logic              fault,
  input logic [TCNT_W-1:0] edge_count
);
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    (gate_hi & gate_lo) == 3'b000);

  p_single_high_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gate_hi));

  p_disable_off_r10: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (gate_hi == 3'b000) && (gate_lo == 3'b000));

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> (gate_hi == 3'b000) && (gate_lo == 3'b000));

  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    (edge_count != $past(edge_count)) |-> (edge_count == TCNT_W'($past(edge_count) + 1'b1)));

  for (genvar i = 0; i < 3; i++) begin : g_dead
    p_dead_hi_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[i]) |-> !$past(gate_lo[i]));
    p_dead_lo_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[i]) |-> !$past(gate_hi[i]));
  end
endmodule

bind hall_commutator hc_checker #(.TCNT_W(TCNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .gate_hi    (gate_hi),
  .gate_lo    (gate_lo),
  .fault      (fault),
  .edge_count (edge_count)
);

// File: tb/hall_commutator_tb_top.sv
module hall_commutator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 8;
  localparam int PER = 16;
  localparam int FL  = 3;
  localparam int DT  = 2;
  localparam int TW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          dir = 1'b0;
  logic [PW-1:0] duty = '0;
  logic [2:0]    hall = 3'b101;
  logic [2:0]    gate_hi;
  logic [2:0]    gate_lo;
  logic          fault;
  logic [TW-1:0] edge_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 1'b0;
  bit done     = 1'b0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hall_commutator #(
    .PWM_W(PW), .PWM_PERIOD(PER), .FILTER_LEN(FL), .DEAD_CYCLES(DT), .TCNT_W(TW)
  ) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .dir(dir), .duty(duty), .hall(hall),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault), .edge_count(edge_count)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_s1 [3];
  int m_s2 [3];
  int m_lvl [3];
  int m_run [3];
  int m_prm [3];
  int m_flp [3];
  int m_fault, m_cnt, m_car, m_duty;
  int m_hi [3];
  int m_lo [3];
  int m_wait [3];
  int m_want [3];   // encoded request: hi*2+lo

  function automatic int seq_pos(input int c);
    int order [6] = '{5, 4, 6, 2, 3, 1};
    for (int k = 0; k < 6; k++) if (order[k] == c) return k;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_s1[i] = 0; m_s2[i] = 0; m_lvl[i] = 0; m_run[i] = 0; m_prm[i] = 0; m_flp[i] = 0;
      m_hi[i] = 0; m_lo[i] = 0; m_wait[i] = 0; m_want[i] = 0;
    end
    m_fault = 0; m_cnt = 0; m_car = 0; m_duty = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
      cyc = 0;
    end else begin
      int code, pos, src, snk, ready, on, nf, r;
      int want [3];
      cyc++;
      code  = m_lvl[2]*4 + m_lvl[1]*2 + m_lvl[0];
      ready = m_prm[0] && m_prm[1] && m_prm[2];
      pos   = seq_pos(code);
      on    = (m_car < m_duty);
      src   = pos / 2;
      snk   = ((pos + 1) / 2 + 1) % 3;
      for (int p = 0; p < 3; p++) begin
        want[p] = 0;
        if (ready && !m_fault && pos >= 0) begin
          if (p == (dir ? snk : src)) want[p] = on ? 2 : 1;
          else if (p == (dir ? src : snk)) want[p] = 1;
        end
      end
      nf = m_fault;
      if (ready && pos < 0) nf = 1;
      if (m_flp[0] || m_flp[1] || m_flp[2]) m_cnt = (m_cnt + 1) % (1 << TW);
      m_fault = nf;
      for (int p = 0; p < 3; p++) begin
        if (!enable) begin
          m_hi[p] = 0; m_lo[p] = 0; m_wait[p] = DT; m_want[p] = 0;
        end else if (want[p] != m_want[p]) begin
          m_hi[p] = 0; m_lo[p] = 0; m_wait[p] = DT; m_want[p] = want[p];
        end else if (m_wait[p] > 0) begin
          m_hi[p] = 0; m_lo[p] = 0; m_wait[p]--;
        end else begin
          m_hi[p] = m_want[p] / 2; m_lo[p] = (m_want[p] == 1);
        end
      end
      for (int i = 0; i < 3; i++) begin
        m_flp[i] = 0;
        if (m_prm[i] && m_s2[i] == m_lvl[i]) m_run[i] = 0;
        else if (m_run[i] == FL - 1) begin
          m_flp[i] = m_prm[i]; m_lvl[i] = m_s2[i]; m_prm[i] = 1; m_run[i] = 0;
        end else m_run[i]++;
        m_s2[i] = m_s1[i];
        r = hall[i];
        m_s1[i] = r;
      end
      if (m_car == PER - 1) begin m_car = 0; m_duty = duty; end
      else m_car++;
    end
  end

  // compare every clock; also track off streaks for the dead-time check
  int off_hi [3];
  int off_lo [3];
  int overlap_events = 0;
  logic [2:0] prev_hi = '0;
  logic [2:0] prev_lo = '0;

  always @(negedge clk) begin
    if (cmp_en) begin
      for (int p = 0; p < 3; p++) begin
        check("R4 gate_hi vs model", gate_hi[p], m_hi[p]);
        check("R6 gate_lo vs model", gate_lo[p], m_lo[p]);
        if (gate_hi[p] && !prev_hi[p]) check("R6 lo-off run before hi rise", off_lo[p] >= DT + 1, 1);
        if (gate_lo[p] && !prev_lo[p]) check("R6 hi-off run before lo rise", off_hi[p] >= DT + 1, 1);
        off_hi[p] = gate_hi[p] ? 0 : off_hi[p] + 1;
        off_lo[p] = gate_lo[p] ? 0 : off_lo[p] + 1;
        if (gate_hi[p] && gate_lo[p]) overlap_events++;
      end
      if ($countones(gate_hi) > 1) overlap_events++;
      check("R8 fault vs model", fault, m_fault);
      check("R9 edge_count vs model", edge_count, m_cnt);
      prev_hi = gate_hi;
      prev_lo = gate_lo;
    end else begin
      for (int p = 0; p < 3; p++) begin off_hi[p] = 100; off_lo[p] = 100; end
      prev_hi = '0;
      prev_lo = '0;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic step_hall(input logic [2:0] v, input int hold);
    @(negedge clk);
    hall = v;
    repeat (hold) @(negedge clk);
  endtask

  // watch one gate over a full period: returns number of cycles it was on
  task automatic on_count(input bit hi_side, input int p, output int n);
    n = 0;
    repeat (PER) begin
      @(negedge clk);
      if (hi_side ? gate_hi[p] : gate_lo[p]) n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    cmp_en = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
  endtask

  initial begin
    int n, base;
    int fwd [6] = '{5, 4, 6, 2, 3, 1};
    do_reset();
    // R11 reset state
    check("R11 gate_hi after reset", gate_hi, 0);
    check("R11 gate_lo after reset", gate_lo, 0);
    check("R11 fault after reset", fault, 0);
    check("R11 edge_count after reset", edge_count, 0);

    // R2: code 5, dir 0 -> A high-side PWM, B low-side, C floats
    enable = 1'b1; duty = 8'd8;
    repeat (3 * PER) @(negedge clk);
    on_count(1'b1, 0, n); check("R2 phase A high-side pulses", n > 0, 1);
    on_count(1'b0, 1, n); check("R2 phase B low side held", n, PER);
    on_count(1'b1, 2, n); check("R2 phase C floats hi", n, 0);
    on_count(1'b0, 2, n); check("R2 phase C floats lo", n, 0);

    // R3: dir 1 swaps roles -> B high-side PWM, A low-side
    dir = 1'b1;
    repeat (3 * PER) @(negedge clk);
    on_count(1'b0, 0, n); check("R3 phase A low side held", n, PER);
    on_count(1'b1, 1, n); check("R3 phase B high-side pulses", n > 0, 1);
    dir = 1'b0;
    repeat (3 * PER) @(negedge clk);

    // R4: full duty -> A hi held, A lo never on
    duty = 8'(PER);
    repeat (3 * PER) @(negedge clk);
    on_count(1'b1, 0, n); check("R4 full duty hi held", n, PER);
    on_count(1'b0, 0, n); check("R4 full duty lo off", n, 0);

    // R7: zero duty, then full duty mid-period is held until wrap
    duty = 8'd0;
    repeat (3 * PER) @(negedge clk);
    while (cyc % PER != 5) @(negedge clk);
    duty = 8'(PER);
    while (cyc % PER != PER - 1) @(negedge clk);
    check("R7 lo still on before wrap", gate_lo[0], 1);
    check("R7 hi still off before wrap", gate_hi[0], 0);
    repeat (2 * PER) @(negedge clk);
    check("R7 hi on after wrap", gate_hi[0], 1);
    duty = 8'd8;

    // R1: glitch of FL-1 clocks on line 0 (5 -> 4) is rejected
    base = edge_count;
    @(negedge clk); hall = 3'b100;
    repeat (FL - 1) @(negedge clk);
    hall = 3'b101;
    repeat (20) @(negedge clk);
    check("R1 short glitch not counted", edge_count, base);
    on_count(1'b0, 1, n); check("R1 short glitch keeps sector", n, PER);
    step_hall(3'b100, 20);
    check("R1 long change counted", edge_count, (base + 1) % (1 << TW));

    // R10: enable low clears gates at the next edge
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R10 gates off hi", gate_hi, 0);
    check("R10 gates off lo", gate_lo, 0);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    repeat (2 * PER) @(negedge clk);

    // R9: 300 forward steps wrap the 8-bit counter
    base = edge_count;
    for (int k = 0; k < 300; k++) step_hall(3'(fwd[(k + 2) % 6]), 12);
    repeat (10) @(negedge clk);
    check("R9 counter wrap", edge_count, (base + 300) % (1 << TW));

    // R8: invalid code 000 -> sticky fault, gates off even after valid code
    step_hall(3'b000, 20);
    check("R8 fault on code 000", fault, 1);
    check("R8 gates off on fault", {gate_hi, gate_lo}, 0);
    step_hall(3'b101, 40);
    check("R8 fault sticky", fault, 1);
    check("R8 gates stay off", {gate_hi, gate_lo}, 0);

    // R8: code 111 after fresh reset
    hall = 3'b101;
    do_reset();
    repeat (20) @(negedge clk);
    check("R8 clean after reset", fault, 0);
    step_hall(3'b111, 20);
    check("R8 fault on code 111", fault, 1);

    // R5 aggregated over the whole run
    check("R5 overlap or double high events", overlap_events, 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end
endmodule